// File: doc/BRIEF.md
# Latched Error Status Register with Error Interrupt Entry

This block gathers error strobes from the surrounding interrupt logic into a hidden accumulator. Each strobe is one cycle wide and sets its own bit. Software never reads the accumulator directly. Any write to the visible status register copies the accumulator into the visible register and clears the accumulator in the same step. Reads therefore return a stable snapshot, and new errors collect in the background until the next write.

Alongside the status register sits an error vector entry. It holds an interrupt vector number, a mask bit and a read-only delivery-status bit. When an error strobe meets the interrupt condition and the entry is unmasked, the block raises `irq_req` with the entry's vector. The request stays pending until the interrupt sink pulses `irq_ack`.

A parameter chooses the interrupt condition. The block can interrupt on any bit that is newly set, or only on the first error to arrive while the accumulator is empty.

Top module: `error_status_latch`

## Requirements
- R1: An error strobe on `err_evt[i]` sets bit i of the hidden accumulator. The bit stays set until the next write to the status register.
- R2: The visible status word changes only on a write with `reg_sel`=0. Reads, vector entry writes and error strobes leave it unchanged.
- R3: A write with `reg_sel`=0 loads the accumulator into the visible status register and clears the accumulator. The value on `reg_wdata` has no effect.
- R4: A strobe in the same cycle as a status write is left out of the snapshot taken by that write. It lands in the cleared accumulator and appears in the next snapshot.
- R5: The status bits are assigned as follows:
  - bit 0: illegal register address
  - bit 1: illegal vector received
  - bit 2: illegal vector sent
  - bit 3: redirectable inter-processor interrupt
  - bit 4: receive accept error
  - bit 5: send accept error
  - bit 6: receive checksum error
  - bit 7: send checksum error
  - bits 31:8 read 0
- R6: A new interrupt request starts only if the mask bit is 0 in the cycle the strobe arrives. Masked errors still accumulate.
- R7: The vector entry (`reg_sel`=1) has this layout:
  - vector in bits 7:0
  - delivery status in bit 12, read-only, 1 means pending
  - mask in bit 16
  - all other bits read 0

  Writes to bit 12 are ignored. `irq_vector` always shows the stored vector.
- R8: After a triggering strobe, delivery status and `irq_req` read 1 from the next cycle on. Both return to 0 in the cycle after `irq_ack` is seen, unless a new trigger arrives in that same cycle.
- R9: With `IRQ_ON_FRESH`=1, a trigger is any strobe bit not already set in the accumulator, where a same-cycle status write counts as having cleared it first. With `IRQ_ON_FRESH`=0, a trigger is any strobe that arrives while that accumulator is all zero.
- R10: After synchronous reset the following hold:
  - accumulator and status are 0
  - `irq_req` is 0
  - the vector is 0
  - the mask is 1
- R11: `reg_rdata` loads the selected register one cycle after `reg_rd`, showing the values from before that cycle's writes. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | ERR_W | One-cycle error strobes, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = status register, 1 = error vector entry |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_req | output | 1 | Error interrupt pending |
| irq_vector | output | VEC_W | Vector of the error entry |
| irq_ack | input | 1 | Interrupt accepted by the sink |

## Verification
The in-line assertions check the following relations on every cycle:
- the accumulator only gains bits between status writes
- the snapshot holds between writes and equals the old accumulator after a write
- a status write leaves only the same-cycle strobes in the accumulator
- an unmasked trigger always leads to a pending request
- a masked entry never starts one
- an acknowledge without a new trigger clears the request

Some behaviour is visible only at the ports, so only the bench scenarios can show it: the exact bit assignment, the ignored write data, and the difference between the two interrupt policies. The bench runs both policies side by side against a model derived from the requirements. It sweeps single-bit strobes and all 256 strobe patterns, with status writes, reads and acknowledges interleaved.

// File: rtl/errlat_pkg.sv
package errlat_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENTRY  = 1'b1
  } reg_sel_e;

  localparam int ERR_BAD_REG_ADDR = 0;
  localparam int ERR_RX_BAD_VEC   = 1;
  localparam int ERR_TX_BAD_VEC   = 2;
  localparam int ERR_REDIR_IPI    = 3;
  localparam int ERR_RX_ACCEPT    = 4;
  localparam int ERR_TX_ACCEPT    = 5;
  localparam int ERR_RX_CHKSUM    = 6;
  localparam int ERR_TX_CHKSUM    = 7;
  localparam int ERR_COUNT        = 8;

  localparam int ENT_DS_BIT   = 12;
  localparam int ENT_MASK_BIT = 16;
endpackage

// File: rtl/errlat_accum.sv
module errlat_accum #(
  parameter int ERR_W        = 8,
  parameter bit IRQ_ON_FRESH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err_evt,
  input  logic             snap_wr,
  output logic [ERR_W-1:0] status_q,
  output logic             trig
);
  logic [ERR_W-1:0] temp_q;
  logic [ERR_W-1:0] temp_eff;

  // A status write clears the accumulator before this cycle's strobes land
  assign temp_eff = snap_wr ? '0 : temp_q;

  generate
    if (IRQ_ON_FRESH) begin : g_fresh
      assign trig = |(err_evt & ~temp_eff);
    end else begin : g_first
      assign trig = (temp_eff == '0) && (err_evt != '0);
    end
  endgenerate

  generate
    for (genvar i = 0; i < ERR_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          temp_q[i]   <= 1'b0;
          status_q[i] <= 1'b0;
        end else begin
          temp_q[i] <= temp_eff[i] | err_evt[i];
          if (snap_wr) status_q[i] <= temp_q[i];
        end
      end
    end
  endgenerate

  assert_accum_grows_R1: assert property (@(posedge clk) disable iff (rst)
    !snap_wr |=> ((temp_q & $past(temp_q)) == $past(temp_q)));
  assert_status_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !snap_wr |=> $stable(status_q));
  assert_snapshot_R3: assert property (@(posedge clk) disable iff (rst)
    snap_wr |=> (status_q == $past(temp_q)));
  assert_same_cycle_evt_R4: assert property (@(posedge clk) disable iff (rst)
    snap_wr |=> (temp_q == $past(err_evt)));
endmodule

// File: rtl/errlat_entry.sv
module errlat_entry #(
  parameter int VEC_W    = 8,
  parameter int DATA_W   = 32,
  parameter int MASK_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig,
  input  logic              irq_ack,
  output logic [VEC_W-1:0]  vec_q,
  output logic              mask_q,
  output logic              pend_q
);
  logic fire;
  assign fire = trig && !mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
    end else if (ent_wr) begin
      vec_q  <= wdata[VEC_W-1:0];
      mask_q <= wdata[MASK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (fire)    pend_q <= 1'b1;
    else if (irq_ack) pend_q <= 1'b0;
  end

  assert_unmasked_raises_R6: assert property (@(posedge clk) disable iff (rst)
    (trig && !mask_q) |=> pend_q);
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !pend_q) |=> !pend_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !trig) |=> !pend_q);
  assert_pend_needs_trig_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(trig));
endmodule

// File: rtl/error_status_latch.sv
module error_status_latch
  import errlat_pkg::*;
#(
  parameter int ERR_W        = ERR_COUNT,
  parameter int VEC_W        = 8,
  parameter int DATA_W       = 32,
  parameter bit IRQ_ON_FRESH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack
);
  localparam int PAD_W = DATA_W - ERR_W;

  logic             snap_wr, ent_wr, trig, mask_q, pend_q;
  logic [ERR_W-1:0] status_q;
  logic [VEC_W-1:0] vec_q;
  logic [DATA_W-1:0] ent_word, stat_word;

  assign snap_wr = reg_wr && (reg_sel == SEL_STATUS);
  assign ent_wr  = reg_wr && (reg_sel == SEL_ENTRY);

  errlat_accum #(.ERR_W(ERR_W), .IRQ_ON_FRESH(IRQ_ON_FRESH)) u_accum (
    .clk(clk), .rst(rst), .err_evt(err_evt), .snap_wr(snap_wr),
    .status_q(status_q), .trig(trig)
  );

  errlat_entry #(.VEC_W(VEC_W), .DATA_W(DATA_W), .MASK_BIT(ENT_MASK_BIT)) u_entry (
    .clk(clk), .rst(rst), .ent_wr(ent_wr), .wdata(reg_wdata), .trig(trig),
    .irq_ack(irq_ack), .vec_q(vec_q), .mask_q(mask_q), .pend_q(pend_q)
  );

  always_comb begin
    ent_word               = '0;
    ent_word[VEC_W-1:0]    = vec_q;
    ent_word[ENT_DS_BIT]   = pend_q;
    ent_word[ENT_MASK_BIT] = mask_q;
  end

  assign stat_word = {{PAD_W{1'b0}}, status_q};

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (reg_sel == SEL_ENTRY) ? ent_word : stat_word;
  end

  assign irq_req    = pend_q;
  assign irq_vector = vec_q;

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  assert_ds_matches_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == SEL_ENTRY) |=> (reg_rdata[ENT_DS_BIT] == $past(irq_req)));
endmodule

// File: tb/error_status_latch_tb.sv
module error_status_latch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  err_evt = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0, irq_ack = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  logic [7:0]  vec_a, vec_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  error_status_latch #(.IRQ_ON_FRESH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .err_evt(err_evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
    .irq_req(irq_a), .irq_vector(vec_a), .irq_ack(irq_ack));

  error_status_latch #(.IRQ_ON_FRESH(1'b0)) u_dut_once (
    .clk(clk), .rst(rst), .err_evt(err_evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
    .irq_req(irq_b), .irq_vector(vec_b), .irq_ack(irq_ack));

  // Requirement model: index 0 = fresh-bit policy, 1 = first-error policy
  logic [7:0]  m_temp [2];
  logic [7:0]  m_stat;
  logic        m_pend [2];
  logic        m_mask;
  logic [7:0]  m_vec;
  logic [31:0] m_rd [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] evt, input logic wr, input logic sel,
                      input logic [31:0] wd, input logic rd, input logic ack,
                      input string tag);
    logic [7:0]  eff [2];
    logic        trig [2];
    logic [7:0]  n_temp [2];
    logic        n_pend [2];
    logic [31:0] n_rd [2];
    logic [7:0]  n_stat;
    logic        n_mask;
    logic [7:0]  n_vec;
    @(negedge clk);
    err_evt = evt; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    reg_rd = rd; irq_ack = ack;
    for (int k = 0; k < 2; k++) begin
      eff[k]    = (wr && !sel) ? 8'h00 : m_temp[k];
      trig[k]   = (k == 0) ? ((evt & ~eff[k]) != 0) : ((eff[k] == 0) && (evt != 0));
      n_temp[k] = eff[k] | evt;
      n_pend[k] = (trig[k] && !m_mask) || (m_pend[k] && !ack);
      n_rd[k]   = !rd ? m_rd[k] :
                  sel ? {15'd0, m_mask, 3'd0, m_pend[k], 4'd0, m_vec} : {24'd0, m_stat};
    end
    n_stat = (wr && !sel) ? m_temp[0] : m_stat;
    n_mask = (wr && sel) ? wd[16] : m_mask;
    n_vec  = (wr && sel) ? wd[7:0] : m_vec;
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      m_temp[k] = n_temp[k]; m_pend[k] = n_pend[k]; m_rd[k] = n_rd[k];
    end
    m_stat = n_stat; m_mask = n_mask; m_vec = n_vec;
    chk({tag, " R6 R8 R9 irq fresh"}, {31'd0, irq_a}, {31'd0, m_pend[0]});
    chk({tag, " R6 R8 R9 irq first"}, {31'd0, irq_b}, {31'd0, m_pend[1]});
    chk({tag, " R7 vector"}, {24'd0, vec_a}, {24'd0, m_vec});
    chk({tag, " R11 rdata fresh"}, rdata_a, m_rd[0]);
    chk({tag, " R11 rdata first"}, rdata_b, m_rd[1]);
    err_evt = '0; reg_wr = 0; reg_rd = 0; irq_ack = 0;
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_temp[k] = '0; m_pend[k] = 0; m_rd[k] = '0;
    end
    m_stat = '0; m_mask = 1'b1; m_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state seen through both registers
    step(8'h00, 0, 0, 32'h0, 1, 0, "R10 status");
    step(8'h00, 0, 1, 32'h0, 1, 0, "R10 entry");
    // R6 masked after reset: errors accumulate, no request
    step(8'h81, 0, 0, 32'h0, 0, 0, "R6 masked");
    step(8'h00, 1, 0, 32'h0, 0, 0, "R3 snap");
    step(8'h00, 0, 0, 32'h0, 1, 0, "R6 accumulated");
    // R7 unmask, vector 0x5A, delivery-status bit written but ignored
    step(8'h00, 1, 1, 32'h0000_105A, 0, 0, "R7 write");
    step(8'h00, 0, 1, 32'h0, 1, 0, "R7 read");

    // R1 R5 single-bit sweep, write data varied to show R3
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 0, 0, 32'h0, 0, 0, "R1 strobe");
      step(8'h00, 0, 1, 32'h0, 1, 0, "R8 pending");
      step(8'h00, 1, 0, (i % 2) ? 32'hFFFF_FFFF : 32'h0, 0, 1, "R3 snap ack");
      step(8'h00, 0, 0, 32'h0, 1, 0, "R5 bit");
    end

    // R9 R4 R2 sweep of every strobe pattern
    for (int v = 0; v < 256; v++) begin
      step(8'(v), (v % 11 == 0), 0, 32'(v * 37), (v % 7 == 3), (v % 3 == 0), "R9 sweep");
      if (v % 5 == 4) step(8'h00, 1, 0, 32'hA5A5_A5A5, 0, 0, "R3 sweep");
      if (v % 4 == 1) step(8'h00, 0, 0, 32'h0, 1, 0, "R2 read");
      if (v % 13 == 6) step(8'(v ^ 8'hFF), 1, 0, 32'h0, 1, 0, "R4 same cycle");
      if (v % 13 == 6) step(8'h00, 1, 0, 32'h0, 0, 0, "R4 next snap");
      if (v % 13 == 6) step(8'h00, 0, 0, 32'h0, 1, 1, "R4 visible");
    end

    // R6 remask: no new request even with fresh bits
    step(8'h00, 0, 0, 32'h0, 0, 1, "R8 ack");
    step(8'h00, 1, 1, 32'h0001_0033, 0, 0, "R6 mask");
    step(8'h0F, 0, 0, 32'h0, 0, 0, "R6 masked evt");
    step(8'hF0, 0, 1, 32'h0, 1, 0, "R6 still quiet");
    // R8 ack and trigger same cycle keeps request
    step(8'h00, 1, 1, 32'h0000_0033, 0, 0, "R7 unmask");
    step(8'h00, 1, 0, 32'h0, 0, 0, "R3 clear");
    step(8'h01, 0, 0, 32'h0, 0, 0, "R8 raise");
    step(8'h02, 0, 0, 32'h0, 0, 1, "R8 ack collide");
    step(8'h00, 0, 0, 32'h0, 0, 1, "R8 ack");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule